// File: doc/BRIEF.md
# Sequential Read Prefetch Buffer with Suspend and Flush Control

This block sits between a CPU read port and a slower external read bus. While prefetching is allowed it keeps fetching consecutive word addresses into a small FIFO, one bus request at a time. A CPU read whose address matches the oldest buffered word is answered in the same cycle straight from the buffer. Any other address is a miss: the buffer is emptied, the missed word is fetched on demand, and sequential prefetching carries on from the word after it.

A one-byte control register holds two live bits. The hold bit (bit 6) stops speculative bus requests. The flush bit (bit 5) is a command: writing 1 to it discards every buffered word and any data still on its way from the bus. It reads back as 1 until no bus request is left open, and then returns to 0 by itself. Software normally sets the hold bit before flushing, so that nothing refills the buffer during the flush. A single write that sets both bits is also handled.

The external bus is a request/acknowledge handshake. The block holds the request and the address steady until it sees a one-cycle acknowledge, and the read data is valid in the acknowledge cycle.

Top module: `pfb_top`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, `cfg_rdata` reads 0x00 (hold bit 6 = 0, flush bit 5 = 0), and no CPU acknowledge is given.
- R2: Writing `cfg_wdata` with bit 5 = 1 discards every buffered word, so the next read of a previously buffered address misses.
- R3: After a flush write, bit 5 of `cfg_rdata` reads 1 until no bus request is outstanding, then returns to 0 by itself. No bus request is issued while it reads 1.
- R4: A write with bit 5 = 0 starts no flush. Buffered words stay valid and still hit.
- R5: While the hold bit (bit 6) is 1, no prefetch request is issued. Only the single demand fetch for a CPU miss may use the bus.
- R6: A single write with bits 6 and 5 both set reads back 0x60, then settles to 0x40 once the flush completes, and leaves the bus idle afterwards.
- R7: Bits 7 and 4:0 of `cfg_rdata` always read 0, and writes to them have no effect on the buffer.
- R8: A CPU read whose address equals the oldest buffered word's address is acknowledged in the same cycle, with that word's data, and the word is consumed.
- R9: A miss empties the buffer, fetches the missed word, and then prefetches from the missed address plus one.
- R10: Bus data whose request was issued before a flush or a miss is discarded when it arrives, and that word is fetched again later if it is needed.
- R11: The buffer never holds more than DEPTH words (default 4), and no request is issued while it is full.
- R12: Once `bus_req` is raised, it and `bus_addr` stay stable until the cycle in which `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bit 6 hold, bit 5 flush) |
| cfg_rdata | output | 8 | Control register read value |
| cpu_req | input | 1 | CPU read request, held until acknowledged |
| cpu_addr | input | AW (16) | CPU word address |
| cpu_ack | output | 1 | Read served from the buffer this cycle |
| cpu_rdata | output | DW (32) | Data for the served read |
| bus_req | output | 1 | External fetch request |
| bus_addr | output | AW (16) | External fetch word address |
| bus_ack | input | 1 | One-cycle fetch acknowledge |
| bus_rdata | input | DW (32) | Fetch data, valid with `bus_ack` |

## Verification
The bench holds the bus acknowledge back so that a flush, and separately a miss, arrives while a fetch is still open. A design that accepts the late data would return the wrong word on the next read, and a design that ends the flush early would show bit 5 cleared while `bus_req` is still high. Two further checks confirm that the bus stays idle: one with the hold bit set and the buffer drained, one with the buffer full. A design that refills under hold or overruns the FIFO would raise a request there. The bench also writes flush-bit-zero and reserved-bit patterns and then reads the buffered head. A design that treats such a write as a flush turns that same-cycle hit into a multi-cycle miss.

// File: rtl/pfb_pkg.sv
// Shared constants and helpers for the prefetch buffer.
// Assumes an 8-bit control register with hold at bit 6 and flush at bit 5.
package pfb_pkg;
    localparam int CTL_W    = 8;
    localparam int HOLD_BIT = 6;
    localparam int FLSH_BIT = 5;

    // Build the control read image; every other bit reads zero.
    function automatic logic [CTL_W-1:0] ctl_image(input logic hold, input logic flushing);
        logic [CTL_W-1:0] v;
        v           = '0;
        v[HOLD_BIT] = hold;
        v[FLSH_BIT] = flushing;
        return v;
    endfunction
endpackage

// File: rtl/pfb_ctl_reg.sv
// Control register: holds the hold bit and sequences the self-clearing flush.
// Assumes bus_busy is high whenever an external request is outstanding.
module pfb_ctl_reg
    import pfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hold,
    input  logic             wr_flush,
    input  logic             bus_busy,
    output logic             hold,
    output logic             flushing,
    output logic             flush_start,
    output logic [CTL_W-1:0] rdata
);
    // A flush begins in the cycle its write is seen.
    assign flush_start = wr_en && wr_flush;

    // Hold bit follows every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold <= 1'b0;
        else if (wr_en) hold <= wr_hold;
    end

    // Flush stays busy until no bus request remains open.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flushing <= 1'b0;
        else if (flush_start)           flushing <= 1'b1;
        else if (flushing && !bus_busy) flushing <= 1'b0;
    end

    // Read image with reserved bits forced to zero.
    assign rdata = ctl_image(hold, flushing);
endmodule

// File: rtl/pfb_fifo.sv
// Word FIFO with pointers plus an occupancy count and a whole-buffer flush.
// Assumes the caller never pushes when full and never pops when empty.
module pfb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update; flush empties everything at once.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/pfb_fetch.sv
// Fetch issue engine: one outstanding bus request, miss restart, stale discard.
// Assumes bus_ack is a single-cycle pulse answering the open request.
module pfb_fetch #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          flushing,
    input  logic          flush_start,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic          hit,
    input  logic [CW-1:0] count,
    input  logic          bus_ack,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [AW-1:0] fetch_addr,
    output logic          push,
    output logic          flush,
    output logic          demand_pend
);
    logic miss, ack, issue, discard;

    // Classify the current cycle's events.
    always_comb begin
        miss  = cpu_req && !hit && !demand_pend;
        flush = miss || flush_start;
        ack   = bus_req && bus_ack;
        push  = ack && !discard && !flush;
        issue = !bus_req && !flushing && !flush_start && !miss
                && (count < CW'(DEPTH)) && (!hold || demand_pend);
    end

    // Request line and latched address for the external bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req  <= 1'b0;
            bus_addr <= '0;
        end else if (issue) begin
            bus_req  <= 1'b1;
            bus_addr <= fetch_addr;
        end else if (ack) begin
            bus_req  <= 1'b0;
        end
    end

    // Mark an open request as stale when a flush overtakes it.
    always_ff @(posedge clk) begin
        if (!rst_n || ack)          discard <= 1'b0;
        else if (flush && bus_req)  discard <= 1'b1;
    end

    // Next address to enqueue: restart on miss, rewind on flush, step on fill.
    always_ff @(posedge clk) begin
        if (!rst_n)           fetch_addr <= '0;
        else if (miss)        fetch_addr <= cpu_addr;
        else if (flush_start) fetch_addr <= fetch_addr - AW'(count) + AW'(hit);
        else if (push)        fetch_addr <= fetch_addr + 1'b1;
    end

    // Demand fetch pending between a miss and its data arriving.
    always_ff @(posedge clk) begin
        if (!rst_n)    demand_pend <= 1'b0;
        else if (miss) demand_pend <= 1'b1;
        else if (push) demand_pend <= 1'b0;
    end
endmodule

// File: rtl/pfb_top.sv
// Prefetch buffer top: control register, fetch engine and word FIFO.
// Assumes the CPU holds cpu_req and cpu_addr stable until cpu_ack.
module pfb_top
    import pfb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic [CTL_W-1:0] cfg_rdata,
    input  logic             cpu_req,
    input  logic [AW-1:0]    cpu_addr,
    output logic             cpu_ack,
    output logic [DW-1:0]    cpu_rdata,
    output logic             bus_req,
    output logic [AW-1:0]    bus_addr,
    input  logic             bus_ack,
    input  logic [DW-1:0]    bus_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          hold, flushing, flush_start, flush, push, demand_pend, hit;
    logic [CW-1:0] count;
    logic [AW-1:0] fetch_addr, head_addr;

    pfb_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
        .wr_hold(cfg_wdata[HOLD_BIT]), .wr_flush(cfg_wdata[FLSH_BIT]),
        .bus_busy(bus_req), .hold(hold), .flushing(flushing),
        .flush_start(flush_start), .rdata(cfg_rdata)
    );

    pfb_fetch #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .hold(hold), .flushing(flushing),
        .flush_start(flush_start), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .hit(hit), .count(count), .bus_ack(bus_ack), .bus_req(bus_req),
        .bus_addr(bus_addr), .fetch_addr(fetch_addr), .push(push),
        .flush(flush), .demand_pend(demand_pend)
    );

    pfb_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_data(bus_rdata), .pop(hit), .head_data(cpu_rdata), .count(count)
    );

    // Head address is implied by the next fill address minus occupancy.
    always_comb begin
        head_addr = fetch_addr - AW'(count);
        hit       = cpu_req && (count != '0) && (cpu_addr == head_addr);
        cpu_ack   = hit;
    end
endmodule

// File: rtl/pfb_chk.sv
// Protocol and sequencing checks for pfb_top, attached by bind.
module pfb_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          hold,
    input logic          flushing,
    input logic          demand_pend,
    input logic [CW-1:0] count,
    input logic          cfg_wr,
    input logic [7:0]    cfg_wdata
);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr));
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && hold && !demand_pend |=> !bus_req);
    assert_flush_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flushing && bus_req |=> flushing);
    assert_flush_no_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flushing && !bus_req |=> !bus_req);
    assert_flush_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |-> count == '0);
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_both_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata[6] && cfg_wdata[5] |=> hold && flushing);
    assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);
endmodule

bind pfb_top pfb_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .cpu_req(cpu_req), .cpu_ack(cpu_ack), .hold(hold),
    .flushing(flushing), .demand_pend(demand_pend), .count(count),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata)
);

// File: tb/sim_pfb_top.sv
module sim_pfb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 32, DEPTH = 4, LAT = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_wdata = '0, cfg_rdata;
    logic          cpu_req = 1'b0, cpu_ack;
    logic [AW-1:0] cpu_addr = '0, bus_addr;
    logic [DW-1:0] cpu_rdata, bus_rdata;
    logic          bus_req, bus_ack;
    logic          bus_hold = 1'b0;
    int            lat;
    int            n_chk = 0, n_fail = 0;
    logic [DW-1:0] exp_q [$];

    pfb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    // External memory model with a fixed latency and a stall control.
    assign bus_rdata = word_at(bus_addr);
    always @(posedge clk) begin
        if (!rst_n)                    begin bus_ack <= 1'b0; lat <= 0; end
        else if (bus_ack)              begin bus_ack <= 1'b0; lat <= 0; end
        else if (bus_req && !bus_hold) begin
            if (lat == LAT) bus_ack <= 1'b1;
            else            lat <= lat + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pop the expected word on every CPU acknowledge.
    always begin
        @(negedge clk);
        #4;
        if (rst_n && cpu_ack) begin
            if (exp_q.size() == 0) check(1'b0, "R8 unexpected ack", cpu_rdata, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(cpu_rdata == e, "R8/R9/R10 read data", cpu_rdata, e);
            end
        end
    end

    task automatic cpu_read(input logic [AW-1:0] a, output int cyc);
        bit got;
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = a;
        exp_q.push_back(word_at(a));
        cyc = 0;
        do begin
            #4;
            got = cpu_ack;
            cyc++;
            @(negedge clk);
        end while (!got && cyc < 200);
        cpu_req = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        #4;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #4;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [AW-1:0] held;
        repeat (3) @(negedge clk);
        #4;
        check(cfg_rdata == 8'h00, "R1 reset control", cfg_rdata, 0);
        check(!bus_req && !cpu_ack, "R1 reset idle", {bus_req, cpu_ack}, 0);
        @(negedge clk) rst_n = 1'b1;

        idle(30);
        cpu_read(16'd0, cyc);
        check(cyc == 1, "R8 head hit in one cycle", cyc, 1);
        for (int a = 1; a < 6; a++) cpu_read(16'(a), cyc);
        idle(30);
        check(!bus_req, "R11 no request when full", bus_req, 0);
        cpu_read(16'd6, cyc);
        check(cyc == 1, "R11 buffered word hits", cyc, 1);

        cfg_write(8'h00);
        check(cfg_rdata == 8'h00, "R4 zero write keeps flush low", cfg_rdata, 0);
        cpu_read(16'd7, cyc);
        check(cyc == 1, "R4 buffer kept after zero write", cyc, 1);

        cfg_write(8'h9F);
        check(cfg_rdata == 8'h00, "R7 reserved bits read zero", cfg_rdata, 0);
        cpu_read(16'd8, cyc);
        check(cyc == 1, "R7 reserved write ignored", cyc, 1);

        idle(30);
        cpu_read(16'd300, cyc);
        check(cyc > 1, "R9 miss takes a bus fetch", cyc, 2);
        idle(30);
        cpu_read(16'd301, cyc);
        check(cyc == 1, "R9 prefetch from miss plus one", cyc, 1);

        cfg_write(8'h40);
        check(cfg_rdata == 8'h40, "R5 hold bit reads back", cfg_rdata, 8'h40);
        idle(20);
        for (int a = 302; a < 306; a++) cpu_read(16'(a), cyc);
        idle(20);
        check(!bus_req, "R5 no refill under hold", bus_req, 0);
        cpu_read(16'd306, cyc);
        check(cyc > 1, "R5 demand fetch under hold", cyc, 2);
        idle(10);
        check(!bus_req, "R5 idle after demand fetch", bus_req, 0);

        cfg_write(8'h00);
        idle(30);
        cfg_write(8'h40);
        cfg_write(8'h60);
        check(cfg_rdata == 8'h60, "R3 flush bit reads one", cfg_rdata, 8'h60);
        idle(1);
        check(cfg_rdata == 8'h40, "R3 flush bit self clears", cfg_rdata, 8'h40);
        cpu_read(16'd307, cyc);
        check(cyc > 1, "R2 flushed word misses", cyc, 2);

        bus_hold = 1'b1;
        cfg_write(8'h00);
        idle(5);
        check(bus_req, "R12 request pending", bus_req, 1);
        held = bus_addr;
        cfg_write(8'h60);
        check(cfg_rdata == 8'h60, "R6 both bits accepted", cfg_rdata, 8'h60);
        idle(5);
        check(cfg_rdata == 8'h60, "R3 flush waits for ack", cfg_rdata, 8'h60);
        check(bus_addr == held, "R12 address stable", bus_addr, held);
        bus_hold = 1'b0;
        idle(10);
        check(cfg_rdata == 8'h40, "R6 flush completes under hold", cfg_rdata, 8'h40);
        check(!bus_req, "R6 no refill after flush", bus_req, 0);
        cfg_write(8'h00);
        cpu_read(16'd308, cyc);

        idle(30);
        bus_hold = 1'b1;
        cpu_read(16'd309, cyc);
        idle(3);
        check(bus_req, "R10 fetch in flight", bus_req, 1);
        fork
            cpu_read(16'd500, cyc);
            begin repeat (6) @(negedge clk); bus_hold = 1'b0; end
        join
        check(cyc > 1, "R10 miss over in-flight fetch", cyc, 2);
        idle(30);
        cpu_read(16'd501, cyc);
        check(cyc == 1, "R10 stale data dropped", cyc, 1);

        idle(5);
        check(exp_q.size() == 0, "R8 all reads acknowledged", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule